// File: doc/BRIEF.md
# Interrupt Distributor Register Front End

This block is the register file that sits in front of a simplified interrupt distributor. The distributor supports one security state and one interrupt group. Software reaches it through a 32-bit read/write request bus. Through that bus it enables the distributor, reads the fixed type and identity words, and changes per-interrupt enable, pending and active flags. Each flag has a pair of words: one sets bits and one clears them. A byte-wide priority value can be stored for each interrupt. The priority is kept only so software can read it back; it has no effect on signalling.

Interrupt IDs 0 to 31 are private to a processor and are not handled here. Their words in the shared arrays read as zero and ignore writes. The block keeps flags only for the shared IDs 32 to `NUM_IRQ-1`. Each flag leaves the block as a vector in which bit `i` stands for ID `32+i`. A forwarded-interrupt vector is driven high for every ID that is enabled and pending, but only while the distributor is enabled. Every address that is not implemented reads zero and ignores writes. This covers the legacy targets, the message set/clear words, the group modifiers, the non-secure access words and the software-generated interrupt words.

A read returns data one cycle after the request. A write changes the state on the clock edge where it is presented.

Top module: `irqdist_regfile`

## Requirements
- R1: The control word at offset 0x000 always reads with bit 4 (forced routing) and bit 5 (single security state) at 1. Bit 0 is the distributor enable and reads back as written. All other bits read 0 and writes to them have no effect.
- R2: The type word at offset 0x004 reads `min(NUM_IRQ,1024)/32 - 1` in bits [4:0] and 9 in bits [23:19]. All other bits read 0 and writes are ignored. With NUM_IRQ=64 the value is 0x00480001.
- R3: The group window at 0x080..0x0FF returns 0xFFFFFFFF for each word that covers implemented IDs (word n covers IDs 32n..32n+31) and 0 for the words above them. Writes to the window are ignored.
- R4: The set words are enable at 0x100, pending at 0x200 and active at 0x300. In these words, word n (offset +4n) covers IDs 32n..32n+31 with ID 32n+k at bit k. Writing 1 to a bit sets that flag. Writing 0 has no effect.
- R5: The clear words are enable at 0x180, pending at 0x280 and active at 0x380. Writing 1 to a bit clears that flag and writing 0 has no effect. A set word and its matching clear word both read the current flag state.
- R6: Word 0 (IDs 0..31) of all six set/clear arrays reads 0, and a write to it changes no flag.
- R7: The priority window starts at 0x400 and holds ID n in byte n (bits 8*(n%4) upward of word n/4). Bytes for IDs 32..NUM_IRQ-1 read back as written. Bytes for IDs 0..31 and for IDs above NUM_IRQ-1 read 0 and ignore writes.
- R8: The identity word at 0xFFE8 reads 0x0000003B. The other words in 0xFFD0..0xFFFC read 0.
- R9: Every other address reads 0, and a write to it changes no flag or register. This includes 0x040 to 0x05C, 0x800 to 0xFFC and any unused offset.
- R10: `irq_fire[i]` is high exactly when the distributor enable is 1 and ID 32+i is both enabled and pending. The active flag does not affect it.
- R11: A read request produces `rd_valid` with `rd_data` on the next cycle and at no other time. A write is visible on the flag outputs in the cycle after it is presented.
- R12: After reset, all flags and the distributor enable are 0, and all priority bytes read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address, word aligned |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after a read request) |
| rd_data | output | 32 | Read data |
| irq_enable | output | NUM_IRQ-32 | Enable flag for IDs 32 upward |
| irq_pending | output | NUM_IRQ-32 | Pending flag for IDs 32 upward |
| irq_active | output | NUM_IRQ-32 | Active flag for IDs 32 upward |
| irq_fire | output | NUM_IRQ-32 | Enabled and pending while distributor is enabled |

## Verification
The bench targets the following corner cases:
- Writes to the private word 0 of every set/clear array. A design that leaked them into storage, or that aliased word 0 onto word 1, would show altered flags afterwards.
- Zeros written to set and clear words, which must leave every flag unchanged. A design that loaded the data directly would wipe flags.
- All ones written to the control word. The bench then checks that only the enable bit moved and that the forced bits stay 1.
- Private, implemented and out-of-range priority bytes. A wrong window decode would read back stale or stray bytes.
- Forwarding with the distributor disabled, and with active set. A design that gated forwarding on the wrong term would fire or drop interrupts.

// File: rtl/irqdist_pkg.sv
package irqdist_pkg;

    localparam int BUS_W      = 32;
    localparam int ADDR_W     = 16;
    localparam int IDX_W      = 8;
    localparam int PRIV_IDS   = 32;
    localparam int ID_BITS_M1 = 9;
    localparam int MAX_IDS    = 1024;

    localparam int CTRL_EN_BIT     = 0;
    localparam int CTRL_ROUTE_BIT  = 4;
    localparam int CTRL_ONESEC_BIT = 5;

    localparam logic [BUS_W-1:0] PERIPH_ID2_VAL = 32'h0000_003B;
    localparam logic [ADDR_W-1:0] PERIPH_ID2_ADDR = 16'hFFE8;

    typedef enum logic [3:0] {
        RG_ZERO,
        RG_CTRL,
        RG_TYPE,
        RG_ONES,
        RG_SET_EN,
        RG_CLR_EN,
        RG_SET_PD,
        RG_CLR_PD,
        RG_SET_AC,
        RG_CLR_AC,
        RG_PRIO,
        RG_PID2
    } region_e;

    typedef struct packed {
        region_e            region;
        logic [IDX_W-1:0]   idx;
    } decode_t;

    function automatic logic [BUS_W-1:0] type_word(input int num_irq);
        int capped;
        logic [BUS_W-1:0] w;
        capped = (num_irq > MAX_IDS) ? MAX_IDS : num_irq;
        w = '0;
        w[4:0]   = 5'(capped / 32 - 1);
        w[23:19] = 5'(ID_BITS_M1);
        return w;
    endfunction

    function automatic logic [BUS_W-1:0] ctrl_word(input logic en);
        logic [BUS_W-1:0] w;
        w = '0;
        w[CTRL_EN_BIT]     = en;
        w[CTRL_ROUTE_BIT]  = 1'b1;
        w[CTRL_ONESEC_BIT] = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/irqdist_decode.sv
module irqdist_decode
    import irqdist_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output decode_t           dec
);
    always_comb begin
        dec.region = RG_ZERO;
        dec.idx    = '0;
        if (addr[ADDR_W-1:2] == '0) begin
            dec.region = RG_CTRL;
        end else if (addr[ADDR_W-1:2] == 14'd1) begin
            dec.region = RG_TYPE;
        end else if (addr[ADDR_W-1:7] == 9'd1) begin
            dec.region = RG_ONES;
            dec.idx    = {3'b000, addr[6:2]};
        end else if (addr[ADDR_W-1:10] == 6'd0 && addr[9:8] != 2'b00) begin
            dec.idx = {3'b000, addr[6:2]};
            case (addr[9:7])
                3'd2:    dec.region = RG_SET_EN;
                3'd3:    dec.region = RG_CLR_EN;
                3'd4:    dec.region = RG_SET_PD;
                3'd5:    dec.region = RG_CLR_PD;
                3'd6:    dec.region = RG_SET_AC;
                default: dec.region = RG_CLR_AC;
            endcase
        end else if (addr[ADDR_W-1:10] == 6'd1) begin
            dec.region = RG_PRIO;
            dec.idx    = addr[9:2];
        end else if (addr[ADDR_W-1:2] == PERIPH_ID2_ADDR[ADDR_W-1:2]) begin
            dec.region = RG_PID2;
        end
    end
endmodule

// File: rtl/irqdist_flag_bank.sv
module irqdist_flag_bank
    import irqdist_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    set_we,
    input  logic                    clr_we,
    input  logic [IDX_W-1:0]        idx,
    input  logic [BUS_W-1:0]        wdata,
    output logic [NUM_IRQ-PRIV_IDS-1:0] flags,
    output logic [BUS_W-1:0]        rd_word
);
    localparam int NUM_WORDS  = NUM_IRQ / 32;
    localparam int SHR_WORDS  = NUM_WORDS - 1;

    // word w of storage is bus word w+1; bus word 0 is private and absent
    for (genvar w = 0; w < SHR_WORDS; w++) begin : g_word
        localparam logic [IDX_W-1:0] BUS_IDX = IDX_W'(w + 1);
        always_ff @(posedge clk) begin
            if (rst) begin
                flags[w*32 +: 32] <= '0;
            end else if (set_we && idx == BUS_IDX) begin
                flags[w*32 +: 32] <= flags[w*32 +: 32] | wdata;
            end else if (clr_we && idx == BUS_IDX) begin
                flags[w*32 +: 32] <= flags[w*32 +: 32] & ~wdata;
            end
        end
    end

    always_comb begin
        rd_word = '0;
        for (int w = 0; w < SHR_WORDS; w++) begin
            if (idx == IDX_W'(w + 1)) rd_word = flags[w*32 +: 32];
        end
    end
endmodule

// File: rtl/irqdist_prio_store.sv
module irqdist_prio_store
    import irqdist_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rd_word
);
    localparam int ALL_WORDS  = NUM_IRQ / 4;
    localparam int PRIV_WORDS = PRIV_IDS / 4;
    localparam int KEPT_WORDS = ALL_WORDS - PRIV_WORDS;

    logic [BUS_W-1:0] mem [KEPT_WORDS];

    for (genvar w = 0; w < KEPT_WORDS; w++) begin : g_word
        localparam logic [IDX_W-1:0] BUS_IDX = IDX_W'(w + PRIV_WORDS);
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[w] <= '0;
            end else if (we && idx == BUS_IDX) begin
                mem[w] <= wdata;
            end
        end
    end

    always_comb begin
        rd_word = '0;
        for (int w = 0; w < KEPT_WORDS; w++) begin
            if (idx == IDX_W'(w + PRIV_WORDS)) rd_word = mem[w];
        end
    end
endmodule

// File: rtl/irqdist_regfile.sv
module irqdist_regfile
    import irqdist_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    input  logic                        req_write,
    input  logic [15:0]                 req_addr,
    input  logic [31:0]                 req_wdata,
    output logic                        rd_valid,
    output logic [31:0]                 rd_data,
    output logic [NUM_IRQ-33:0]         irq_enable,
    output logic [NUM_IRQ-33:0]         irq_pending,
    output logic [NUM_IRQ-33:0]         irq_active,
    output logic [NUM_IRQ-33:0]         irq_fire
);
    localparam int NUM_SPI   = NUM_IRQ - PRIV_IDS;
    localparam int NUM_WORDS = NUM_IRQ / 32;

    decode_t          dec;
    logic             wr_go;
    logic             rd_go;
    logic             dist_en;
    logic [BUS_W-1:0] en_rd, pd_rd, ac_rd, prio_rd;
    logic [BUS_W-1:0] rd_mux;

    assign wr_go = req_valid &&  req_write;
    assign rd_go = req_valid && !req_write;

    irqdist_decode u_dec (
        .addr (req_addr),
        .dec  (dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dist_en <= 1'b0;
        end else if (wr_go && dec.region == RG_CTRL) begin
            dist_en <= req_wdata[CTRL_EN_BIT];
        end
    end

    irqdist_flag_bank #(.NUM_IRQ(NUM_IRQ)) u_en (
        .clk     (clk),
        .rst     (rst),
        .set_we  (wr_go && dec.region == RG_SET_EN),
        .clr_we  (wr_go && dec.region == RG_CLR_EN),
        .idx     (dec.idx),
        .wdata   (req_wdata),
        .flags   (irq_enable),
        .rd_word (en_rd)
    );

    irqdist_flag_bank #(.NUM_IRQ(NUM_IRQ)) u_pd (
        .clk     (clk),
        .rst     (rst),
        .set_we  (wr_go && dec.region == RG_SET_PD),
        .clr_we  (wr_go && dec.region == RG_CLR_PD),
        .idx     (dec.idx),
        .wdata   (req_wdata),
        .flags   (irq_pending),
        .rd_word (pd_rd)
    );

    irqdist_flag_bank #(.NUM_IRQ(NUM_IRQ)) u_ac (
        .clk     (clk),
        .rst     (rst),
        .set_we  (wr_go && dec.region == RG_SET_AC),
        .clr_we  (wr_go && dec.region == RG_CLR_AC),
        .idx     (dec.idx),
        .wdata   (req_wdata),
        .flags   (irq_active),
        .rd_word (ac_rd)
    );

    irqdist_prio_store #(.NUM_IRQ(NUM_IRQ)) u_prio (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_go && dec.region == RG_PRIO),
        .idx     (dec.idx),
        .wdata   (req_wdata),
        .rd_word (prio_rd)
    );

    always_comb begin
        case (dec.region)
            RG_CTRL:             rd_mux = ctrl_word(dist_en);
            RG_TYPE:             rd_mux = type_word(NUM_IRQ);
            RG_ONES:             rd_mux = (dec.idx < IDX_W'(NUM_WORDS)) ? '1 : '0;
            RG_SET_EN, RG_CLR_EN: rd_mux = en_rd;
            RG_SET_PD, RG_CLR_PD: rd_mux = pd_rd;
            RG_SET_AC, RG_CLR_AC: rd_mux = ac_rd;
            RG_PRIO:             rd_mux = prio_rd;
            RG_PID2:             rd_mux = PERIPH_ID2_VAL;
            default:             rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_go;
            if (rd_go) rd_data <= rd_mux;
        end
    end

    assign irq_fire = {NUM_SPI{dist_en}} & irq_enable & irq_pending;
endmodule

// File: rtl/irqdist_regfile_chk.sv
module irqdist_regfile_chk #(
    parameter int NUM_SPI = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_write,
    input logic [15:0]        req_addr,
    input logic [31:0]        req_wdata,
    input logic               rd_valid,
    input logic [31:0]        rd_data,
    input logic [NUM_SPI-1:0] irq_enable,
    input logic [NUM_SPI-1:0] irq_pending,
    input logic [NUM_SPI-1:0] irq_active
);
    // R11
    rd_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rd_valid);

    // R11
    rd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_write) |=> !rd_valid);

    // R1
    ctrl_forced_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_addr == 16'h0000) |=> (rd_data[5:4] == 2'b11));

    // R2
    type_idbits_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_addr == 16'h0004) |=> (rd_data[23:19] == 5'd9));

    // R6
    private_word_wi_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_addr[15:10] == 6'd0 && req_addr[9:8] != 2'b00
         && req_addr[6:2] == 5'd0)
        |=> ($stable(irq_enable) && $stable(irq_pending) && $stable(irq_active)));

    // R4
    set_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_addr == 16'h0204)
        |=> ((irq_pending[31:0] & $past(req_wdata)) == $past(req_wdata)));

    // R5
    clr_enable_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_addr == 16'h0184)
        |=> ((irq_enable[31:0] & $past(req_wdata)) == 32'h0));

    // R9
    legacy_target_wi_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_addr[15:10] == 6'd2)
        |=> ($stable(irq_enable) && $stable(irq_pending) && $stable(irq_active)));
endmodule

bind irqdist_regfile irqdist_regfile_chk #(.NUM_SPI(NUM_SPI)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .irq_enable  (irq_enable),
    .irq_pending (irq_pending),
    .irq_active  (irq_active)
);

// File: tb/tb_irqdist_regfile.sv
module tb_irqdist_regfile;
    localparam int NUM_IRQ = 64;
    localparam int NUM_SPI = NUM_IRQ - 32;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               req_valid = 1'b0;
    logic               req_write = 1'b0;
    logic [15:0]        req_addr  = '0;
    logic [31:0]        req_wdata = '0;
    logic               rd_valid;
    logic [31:0]        rd_data;
    logic [NUM_SPI-1:0] irq_enable, irq_pending, irq_active, irq_fire;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    irqdist_regfile #(.NUM_IRQ(NUM_IRQ)) dut (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .irq_enable  (irq_enable),
        .irq_pending (irq_pending),
        .irq_active  (irq_active),
        .irq_fire    (irq_fire)
    );

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data as results appear
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (sb_q.size() == 0) begin
                check32("R11 unexpected rd_valid", 32'h1, 32'h0);
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                check32(it.tag, rd_data, it.exp);
            end
        end
    end

    task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, input logic [31:0] e, input string tag);
        sb_item_t it;
        @(negedge clk);
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic check_flags(input string tag, input logic [31:0] en, input logic [31:0] pd,
                               input logic [31:0] ac, input logic [31:0] fire);
        check32({tag, " enable"},  irq_enable[31:0],  en);
        check32({tag, " pending"}, irq_pending[31:0], pd);
        check32({tag, " active"},  irq_active[31:0],  ac);
        check32({tag, " fire"},    irq_fire[31:0],    fire);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R12 reset state
        check_flags("R12 reset", 32'h0, 32'h0, 32'h0, 32'h0);
        bus_read(16'h0000, 32'h0000_0030, "R12 R1 ctrl after reset");
        bus_read(16'h0420, 32'h0, "R12 prio after reset");

        // R2 type word
        bus_read(16'h0004, 32'h0048_0001, "R2 type word");
        bus_write(16'h0004, 32'hFFFF_FFFF);
        bus_read(16'h0004, 32'h0048_0001, "R2 type write ignored");

        // R1 control
        bus_write(16'h0000, 32'hFFFF_FFFF);
        bus_read(16'h0000, 32'h0000_0031, "R1 ctrl all ones written");
        bus_write(16'h0000, 32'h0000_0000);
        bus_read(16'h0000, 32'h0000_0030, "R1 ctrl cleared forced bits stay");

        // R3 group window
        bus_write(16'h0084, 32'h0);
        bus_read(16'h0080, 32'hFFFF_FFFF, "R3 group word0");
        bus_read(16'h0084, 32'hFFFF_FFFF, "R3 group word1 after write");
        bus_read(16'h0088, 32'h0, "R3 group beyond ids");

        // R4 / R5 enable set and clear
        bus_write(16'h0104, 32'h0000_00F0);
        check_flags("R4 set enable", 32'h0000_00F0, 32'h0, 32'h0, 32'h0);
        bus_read(16'h0104, 32'h0000_00F0, "R4 set-enable readback");
        bus_read(16'h0184, 32'h0000_00F0, "R5 clear-enable readback");
        bus_write(16'h0104, 32'h0);
        check_flags("R4 zero to set", 32'h0000_00F0, 32'h0, 32'h0, 32'h0);
        bus_write(16'h0184, 32'h0000_0030);
        check_flags("R5 clear enable", 32'h0000_00C0, 32'h0, 32'h0, 32'h0);
        bus_write(16'h0184, 32'h0);
        check_flags("R5 zero to clear", 32'h0000_00C0, 32'h0, 32'h0, 32'h0);

        // R6 private word
        bus_write(16'h0100, 32'hFFFF_FFFF);
        bus_write(16'h0200, 32'hFFFF_FFFF);
        bus_write(16'h0300, 32'hFFFF_FFFF);
        bus_write(16'h0180, 32'hFFFF_FFFF);
        check_flags("R6 private writes", 32'h0000_00C0, 32'h0, 32'h0, 32'h0);
        bus_read(16'h0100, 32'h0, "R6 private set-enable read");
        bus_read(16'h0280, 32'h0, "R6 private clear-pending read");

        // R10 forwarding
        bus_write(16'h0204, 32'h0000_00FF);
        check_flags("R10 disabled no fire", 32'h0000_00C0, 32'h0000_00FF, 32'h0, 32'h0);
        bus_write(16'h0000, 32'h0000_0001);
        check_flags("R10 enabled fire", 32'h0000_00C0, 32'h0000_00FF, 32'h0, 32'h0000_00C0);
        bus_write(16'h0284, 32'h0000_0080);
        check_flags("R5 R10 clear pending", 32'h0000_00C0, 32'h0000_007F, 32'h0, 32'h0000_0040);
        bus_write(16'h0304, 32'h0000_0040);
        check_flags("R4 R10 active no effect", 32'h0000_00C0, 32'h0000_007F, 32'h0000_0040, 32'h0000_0040);
        bus_read(16'h0384, 32'h0000_0040, "R5 clear-active readback");
        bus_read(16'h0284, 32'h0000_007F, "R5 clear-pending readback");
        bus_write(16'h0384, 32'h0000_0040);
        check_flags("R5 clear active", 32'h0000_00C0, 32'h0000_007F, 32'h0, 32'h0000_0040);
        bus_write(16'h0000, 32'h0);
        check_flags("R10 disable again", 32'h0000_00C0, 32'h0000_007F, 32'h0, 32'h0);
        bus_write(16'h0000, 32'h0000_0001);

        // R7 priority
        bus_write(16'h0420, 32'hA1B2_C3D4);
        bus_write(16'h043C, 32'h0102_0304);
        bus_write(16'h0400, 32'h1122_3344);
        bus_write(16'h0440, 32'h5566_7788);
        bus_read(16'h0420, 32'hA1B2_C3D4, "R7 prio first shared");
        bus_read(16'h043C, 32'h0102_0304, "R7 prio last shared");
        bus_read(16'h0400, 32'h0, "R7 prio private");
        bus_read(16'h0440, 32'h0, "R7 prio beyond ids");

        // R8 identity
        bus_read(16'hFFE8, 32'h0000_003B, "R8 id2");
        bus_read(16'hFFE0, 32'h0, "R8 other id");

        // R9 zero regions
        bus_write(16'h0800, 32'hFFFF_FFFF);
        bus_write(16'h0040, 32'hFFFF_FFFF);
        bus_write(16'h0D04, 32'hFFFF_FFFF);
        bus_write(16'h0F00, 32'hFFFF_FFFF);
        bus_write(16'h0E04, 32'hFFFF_FFFF);
        check_flags("R9 zero writes", 32'h0000_00C0, 32'h0000_007F, 32'h0, 32'h0000_0040);
        bus_read(16'h0800, 32'h0, "R9 legacy target read");
        bus_read(16'h0040, 32'h0, "R9 message word read");
        bus_read(16'h0000, 32'h0000_0031, "R9 ctrl unchanged");

        // R11 back-to-back reads then drain
        bus_read(16'h0104, 32'h0000_00C0, "R11 read one");
        bus_read(16'h0204, 32'h0000_007F, "R11 read two");
        repeat (3) @(negedge clk);
        check32("R11 scoreboard drained", 32'(sb_q.size()), 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule